// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests from six sources of a small microcontroller: two active-low external pins, overflow pulses from timers 0, 1 and 2, a timer 2 external-capture pulse, and receive/transmit-done pulses from a serial port. Each request is held in a flag bit. A software register port lets the CPU mask each source, set a global enable, place each source at the high or the low priority level, choose edge or level detection for each external pin, and read or write every flag directly.

Among the enabled requests, the block picks a winner by priority level first and then by a fixed polling order. It presents the winner to the CPU as a vector request with a source ID and a vector address. When the CPU acknowledges, the block records the level as in service. It clears the winning flag only for sources whose flag hardware owns: edge-mode external inputs and timers 0/1. A return pulse from the CPU releases the innermost service level.

Top module: `intc_two_level`

## Requirements
- R1: After reset the enable, priority, mode and flag registers all read 0 and `vec_req` is low.
- R2: In edge mode (mode bit i = 1, select 3), a 1-to-0 transition on `ext_pin_n[i]` sets the external flag (flags bit 0 for pin 0, bit 2 for pin 1) one cycle later. An accepted acknowledge of that source clears the flag.
- R3: In level mode (mode bit i = 0), the external flag equals the inverted pin one cycle later. Software writes to that flag bit have no effect, and an acknowledge does not clear it.
- R4: A pulse on `tmr_ovf[0]`/`tmr_ovf[1]` sets flags bit 1/bit 3. An accepted acknowledge of source 1/3 clears that bit.
- R5: `ser_rx_done`, `ser_tx_done`, `t2_ovf` and `t2_ext` set flags bits 4, 5, 6 and 7. Source 4 requests while bit 4 or 5 is set, and source 5 requests while bit 6 or 7 is set. An acknowledge clears none of these bits.
- R6: A write to select 2 replaces the flag register. A hardware set event in the same cycle is still applied on top of the written value.
- R7: Enable register (select 0) bits 0..5 enable sources 0..5, bit 7 is the global enable, and bit 6 reads 0. With bit 7 clear, no request is presented.
- R8: Priority register (select 1) bits 0..5 put sources 0..5 at the high level when set. An eligible high-level source always wins over any low-level one.
- R9: Within a level, the lowest source ID wins. Source IDs in polling order are: 0 ext pin 0, 1 timer 0, 2 ext pin 1, 3 timer 1, 4 serial, 5 timer 2.
- R10: `vec_addr` equals 0x0003 + 8 × `vec_id` whenever `vec_req` is high.
- R11: An acknowledge while `vec_req` is high marks the winner's level in service. A high-level request may preempt an active low-level service. Nothing is presented while a high-level service is active, and a low-level request is not presented while any service is active.
- R12: A `ret_pulse` releases the high-level service if one is active, and otherwise the low-level service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_n | input | 2 | Active-low external request pins (synchronous to clk) |
| tmr_ovf | input | 2 | Rollover pulses of timers 0 and 1 |
| ser_rx_done | input | 1 | Serial receive-complete pulse |
| ser_tx_done | input | 1 | Serial transmit-complete pulse |
| t2_ovf | input | 1 | Timer 2 rollover pulse |
| t2_ext | input | 1 | Timer 2 external capture/reload pulse |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Register select: 0 enable, 1 priority, 2 flags, 3 pin mode |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Read data of the selected register (combinational) |
| vec_req | output | 1 | Vector request to the CPU |
| vec_id | output | 3 | Winning source ID |
| vec_addr | output | 16 | Vector address of the winner |
| vec_ack | input | 1 | CPU acknowledge of the presented vector |
| ret_pulse | input | 1 | CPU return-from-service pulse |

## Verification
Every flag, enable, priority and in-service bit is registered, and the request outputs are combinational from those registers. A stimulus applied before a rising edge is therefore visible on `vec_req`, `vec_id`, `vec_addr` and `sw_rdata` right after that single edge. The bench drives inputs just after a falling edge and samples at the next falling edge, which is exactly one register stage later. Acknowledge and return pulses are held for that one cycle, and their effect on flags and on the presented vector is read at the following falling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC = 6;
    localparam int DW   = 8;
    localparam int ID_W = $clog2(NSRC);

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PRIO   = 2'd1,
        SEL_FLAGS  = 2'd2,
        SEL_MODE   = 2'd3
    } reg_sel_e;

    // enable register: global bit position
    localparam int EA_BIT = 7;

    // flag register bit positions
    localparam int FB_X0   = 0;
    localparam int FB_T0   = 1;
    localparam int FB_X1   = 2;
    localparam int FB_T1   = 3;
    localparam int FB_RI   = 4;
    localparam int FB_TI   = 5;
    localparam int FB_TF2  = 6;
    localparam int FB_EXF2 = 7;

    // writable-bit masks
    localparam logic [DW-1:0] EN_MASK   = 8'hBF;
    localparam logic [DW-1:0] PRI_MASK  = 8'h3F;
endpackage

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
    import intc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [1:0]    sw_sel,
    input  logic [DW-1:0] sw_wdata,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] pri_q,
    output logic [1:0]    mode_q
);
    typedef struct packed {
        logic [DW-1:0] en;
        logic [DW-1:0] pri;
        logic [1:0]    mode;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_we) begin
            case (reg_sel_e'(sw_sel))
                SEL_ENABLE: st_d.en   = sw_wdata & EN_MASK;
                SEL_PRIO:   st_d.pri  = sw_wdata & PRI_MASK;
                SEL_MODE:   st_d.mode = sw_wdata[1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign pri_q  = st_q.pri;
    assign mode_q = st_q.mode;

    // R7: the unused enable bit never reads back as set
    p_unused_bit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[6]);
endmodule

// File: rtl/intc_flags.sv
module intc_flags
    import intc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ext_pin_n,
    input  logic [1:0]      mode,
    input  logic [1:0]      tmr_ovf,
    input  logic            ser_rx_done,
    input  logic            ser_tx_done,
    input  logic            t2_ovf,
    input  logic            t2_ext,
    input  logic            flag_we,
    input  logic [DW-1:0]   flag_wdata,
    input  logic            ack_fire,
    input  logic [ID_W-1:0] ack_id,
    output logic [DW-1:0]   flags_q,
    output logic [NSRC-1:0] src_req
);
    typedef struct packed {
        logic [DW-1:0] flags;
        logic [1:0]    pin_q;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic [DW-1:0] hw_set;
    logic [DW-1:0] ack_clr;
    logic [DW-1:0] base;
    logic [1:0]    fall;

    always_comb begin
        st_d       = st_q;
        st_d.pin_q = ext_pin_n;
        fall       = st_q.pin_q & ~ext_pin_n;

        hw_set          = '0;
        hw_set[FB_X0]   = fall[0];
        hw_set[FB_X1]   = fall[1];
        hw_set[FB_T0]   = tmr_ovf[0];
        hw_set[FB_T1]   = tmr_ovf[1];
        hw_set[FB_RI]   = ser_rx_done;
        hw_set[FB_TI]   = ser_tx_done;
        hw_set[FB_TF2]  = t2_ovf;
        hw_set[FB_EXF2] = t2_ext;

        ack_clr = '0;
        if (ack_fire) begin
            case (ack_id)
                3'd0:    ack_clr[FB_X0] = mode[0];
                3'd1:    ack_clr[FB_T0] = 1'b1;
                3'd2:    ack_clr[FB_X1] = mode[1];
                3'd3:    ack_clr[FB_T1] = 1'b1;
                default: ack_clr = '0;
            endcase
        end

        base       = flag_we ? flag_wdata : (st_q.flags & ~ack_clr);
        st_d.flags = base | hw_set;
        if (!mode[0]) st_d.flags[FB_X0] = ~ext_pin_n[0];
        if (!mode[1]) st_d.flags[FB_X1] = ~ext_pin_n[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= '0;
            st_q.pin_q <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;
    assign src_req = {st_q.flags[FB_TF2] | st_q.flags[FB_EXF2],
                      st_q.flags[FB_RI]  | st_q.flags[FB_TI],
                      st_q.flags[FB_T1], st_q.flags[FB_X1],
                      st_q.flags[FB_T0], st_q.flags[FB_X0]};

    // R2: a falling pin in edge mode raises the flag on the next edge
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] && st_q.pin_q[0] && !ext_pin_n[0]) |=> flags_q[FB_X0]);

    // R3: a level-mode flag mirrors the inverted pin
    p_level_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> (flags_q[FB_X1] == !$past(ext_pin_n[1])));

    // R4: acknowledged timer 0 flag is cleared
    p_tmr_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && ack_id == 3'd1 && !flag_we && !tmr_ovf[0]) |=> !flags_q[FB_T0]);

    // R5: the receive flag survives an acknowledge of the serial source
    p_serial_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && ack_id == 3'd4 && flags_q[FB_RI] && !flag_we) |=> flags_q[FB_RI]);
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_service.sv
module intc_service
    import intc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic [NSRC-1:0]   src_en,
    input  logic              glob_en,
    input  logic [NSRC-1:0]   src_hi,
    input  logic              vec_ack,
    input  logic              ret_pulse,
    output logic              vec_req,
    output logic [ID_W-1:0]   vec_id,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              ack_fire
);
    typedef struct packed {
        logic hi_act;
        logic lo_act;
    } svc_t;

    svc_t st_d, st_q;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] cand  [2];
    logic            found [2];
    logic [ID_W-1:0] idx   [2];
    logic            win_hi, win_lo;

    assign elig = src_req & src_en & {NSRC{glob_en}};

    // index 0: low level, index 1: high level
    for (genvar g = 0; g < 2; g++) begin : g_level
        assign cand[g] = elig & (g == 1 ? src_hi : ~src_hi);
        intc_pick #(.N(NSRC), .IDX_W(ID_W)) u_pick (
            .req   (cand[g]),
            .found (found[g]),
            .idx   (idx[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        win_hi   = found[1] & ~st_q.hi_act;
        win_lo   = found[0] & ~st_q.hi_act & ~st_q.lo_act;
        vec_req  = win_hi | win_lo;
        vec_id   = win_hi ? idx[1] : idx[0];
        vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(vec_id) * ADDR_W'(VEC_STRIDE);
        ack_fire = vec_ack & vec_req;
        if (ack_fire) begin
            if (win_hi) st_d.hi_act = 1'b1;
            else        st_d.lo_act = 1'b1;
        end else if (ret_pulse) begin
            if (st_q.hi_act) st_d.hi_act = 1'b0;
            else             st_d.lo_act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: global enable off means no request
    p_ea_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !vec_req);

    // R11: nothing is presented during high-level service
    p_hi_not_preempted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hi_act |-> !vec_req);

    // R11: during low-level service only a high-level source is presented
    p_lo_only_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && st_q.lo_act) |-> src_hi[vec_id]);

    // R11: an accepted acknowledge leaves some level in service
    p_ack_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (st_q.hi_act || st_q.lo_act));

    // R12: return releases the high level and keeps the low level
    p_ret_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && !ack_fire && st_q.hi_act) |=> (!st_q.hi_act && st_q.lo_act == $past(st_q.lo_act)));

    // R10: address follows the ID
    p_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (vec_addr[2:0] == 3'd3 && vec_addr[ADDR_W-1:6] == '0));
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ext_pin_n,
    input  logic [1:0]        tmr_ovf,
    input  logic              ser_rx_done,
    input  logic              ser_tx_done,
    input  logic              t2_ovf,
    input  logic              t2_ext,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [DW-1:0]     sw_wdata,
    output logic [DW-1:0]     sw_rdata,
    output logic              vec_req,
    output logic [ID_W-1:0]   vec_id,
    output logic [ADDR_W-1:0] vec_addr,
    input  logic              vec_ack,
    input  logic              ret_pulse
);
    logic [DW-1:0]   en_q, pri_q, flags_q;
    logic [1:0]      mode_q;
    logic [NSRC-1:0] src_req;
    logic            ack_fire;
    logic            flag_we;

    assign flag_we = sw_we && (reg_sel_e'(sw_sel) == SEL_FLAGS);

    intc_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_sel   (sw_sel),
        .sw_wdata (sw_wdata),
        .en_q     (en_q),
        .pri_q    (pri_q),
        .mode_q   (mode_q)
    );

    intc_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pin_n   (ext_pin_n),
        .mode        (mode_q),
        .tmr_ovf     (tmr_ovf),
        .ser_rx_done (ser_rx_done),
        .ser_tx_done (ser_tx_done),
        .t2_ovf      (t2_ovf),
        .t2_ext      (t2_ext),
        .flag_we     (flag_we),
        .flag_wdata  (sw_wdata),
        .ack_fire    (ack_fire),
        .ack_id      (vec_id),
        .flags_q     (flags_q),
        .src_req     (src_req)
    );

    intc_service #(
        .ADDR_W     (ADDR_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .src_en    (en_q[NSRC-1:0]),
        .glob_en   (en_q[EA_BIT]),
        .src_hi    (pri_q[NSRC-1:0]),
        .vec_ack   (vec_ack),
        .ret_pulse (ret_pulse),
        .vec_req   (vec_req),
        .vec_id    (vec_id),
        .vec_addr  (vec_addr),
        .ack_fire  (ack_fire)
    );

    always_comb begin
        case (reg_sel_e'(sw_sel))
            SEL_ENABLE: sw_rdata = en_q;
            SEL_PRIO:   sw_rdata = pri_q;
            SEL_FLAGS:  sw_rdata = flags_q;
            default:    sw_rdata = {6'd0, mode_q};
        endcase
    end
endmodule

// File: tb/sim_intc_two_level.sv
module sim_intc_two_level;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 9;
    // {enable, priority, flags, expected request, expected id}
    localparam logic [39:0] VEC_TBL [NVEC] = '{
        {8'hFF, 8'h00, 8'hFF, 8'h01, 8'h00},
        {8'h7F, 8'h00, 8'hFF, 8'h00, 8'h00},
        {8'hFF, 8'h20, 8'hFF, 8'h01, 8'h05},
        {8'hFF, 8'h0A, 8'h0F, 8'h01, 8'h01},
        {8'h9E, 8'h00, 8'hFF, 8'h01, 8'h01},
        {8'hFF, 8'h00, 8'h20, 8'h01, 8'h04},
        {8'hFF, 8'h00, 8'h40, 8'h01, 8'h05},
        {8'h8C, 8'h04, 8'h0C, 8'h01, 8'h02},
        {8'h80, 8'h00, 8'hFF, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0, t2_ovf = 1'b0, t2_ext = 1'b0;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_sel = 2'd0;
    logic [7:0]  sw_wdata = 8'd0;
    logic [7:0]  sw_rdata;
    logic        vec_req;
    logic [2:0]  vec_id;
    logic [15:0] vec_addr;
    logic        vec_ack = 1'b0, ret_pulse = 1'b0;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intc_two_level u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf),
        .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
        .t2_ovf(t2_ovf), .t2_ext(t2_ext),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .vec_req(vec_req), .vec_id(vec_id), .vec_addr(vec_addr),
        .vec_ack(vec_ack), .ret_pulse(ret_pulse)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] data);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = data;
        step();
        sw_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] sel, logic [7:0] exp);
        sw_sel = sel;
        #1;
        chk(tag, 32'(sw_rdata), 32'(exp));
    endtask

    task automatic vec_chk(string tag, logic exp_req, logic [2:0] exp_id);
        chk({tag, " req"}, 32'(vec_req), 32'(exp_req));
        if (exp_req) begin
            chk({tag, " id"}, 32'(vec_id), 32'(exp_id));
            chk({tag, " addr R10"}, 32'(vec_addr), 32'h3 + 32'(exp_id) * 32'd8);
        end
    endtask

    task automatic ack();
        vec_ack = 1'b1; step(); vec_ack = 1'b0;
    endtask

    task automatic ret();
        ret_pulse = 1'b1; step(); ret_pulse = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd_chk("R1 enable", 2'd0, 8'h00);
        rd_chk("R1 priority", 2'd1, 8'h00);
        rd_chk("R1 flags", 2'd2, 8'h00);
        rd_chk("R1 mode", 2'd3, 8'h00);
        vec_chk("R1", 1'b0, 3'd0);

        // table walk, both pins in edge mode so flags are writable
        wr(2'd3, 8'h03);
        for (int k = 0; k < NVEC; k++) begin
            wr(2'd0, VEC_TBL[k][39:32]);
            wr(2'd1, VEC_TBL[k][31:24]);
            wr(2'd2, VEC_TBL[k][23:16]);
            vec_chk($sformatf("R7 R8 R9 row%0d", k), VEC_TBL[k][8], VEC_TBL[k][2:0]);
        end
        rd_chk("R7 bit6 reads 0", 2'd0, 8'h80);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);

        // R2: edge mode external 0
        wr(2'd0, 8'h81);
        ext_pin_n[0] = 1'b0;
        step();
        rd_chk("R2 flag set", 2'd2, 8'h01);
        vec_chk("R2 vector", 1'b1, 3'd0);
        ack();
        rd_chk("R2 flag cleared by ack", 2'd2, 8'h00);
        ext_pin_n[0] = 1'b1;
        ret();
        rd_chk("R2 rising edge no set", 2'd2, 8'h00);

        // R3: level mode external 1
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h84);
        ext_pin_n[1] = 1'b0;
        step();
        rd_chk("R3 flag follows pin", 2'd2, 8'h04);
        vec_chk("R3 vector", 1'b1, 3'd2);
        wr(2'd2, 8'h00);
        rd_chk("R3 write ignored", 2'd2, 8'h04);
        ack();
        rd_chk("R3 ack keeps flag", 2'd2, 8'h04);
        vec_chk("R3 in service", 1'b0, 3'd0);
        ext_pin_n[1] = 1'b1;
        step();
        rd_chk("R3 flag drops with pin", 2'd2, 8'h00);
        ret();
        wr(2'd3, 8'h03);

        // R4: timer 1 rollover
        wr(2'd0, 8'h88);
        tmr_ovf[1] = 1'b1; step(); tmr_ovf[1] = 1'b0;
        rd_chk("R4 timer flag set", 2'd2, 8'h08);
        vec_chk("R4 vector", 1'b1, 3'd3);
        ack();
        rd_chk("R4 timer flag cleared", 2'd2, 8'h00);
        ret();

        // R5: serial and timer 2 are kept across ack
        wr(2'd0, 8'h90);
        ser_rx_done = 1'b1; step(); ser_rx_done = 1'b0;
        rd_chk("R5 receive flag", 2'd2, 8'h10);
        vec_chk("R5 serial vector", 1'b1, 3'd4);
        ack();
        rd_chk("R5 receive kept", 2'd2, 8'h10);
        ret();
        vec_chk("R5 serial again", 1'b1, 3'd4);
        wr(2'd2, 8'h00);
        vec_chk("R5 software clear", 1'b0, 3'd0);
        wr(2'd0, 8'hA0);
        t2_ext = 1'b1; step(); t2_ext = 1'b0;
        rd_chk("R5 capture flag", 2'd2, 8'h80);
        vec_chk("R5 timer2 vector", 1'b1, 3'd5);
        ack();
        rd_chk("R5 capture kept", 2'd2, 8'h80);
        ret();
        wr(2'd2, 8'h00);

        // R6: software write merges with same-cycle hardware set
        wr(2'd0, 8'h00);
        sw_we = 1'b1; sw_sel = 2'd2; sw_wdata = 8'h00; tmr_ovf[0] = 1'b1;
        step();
        sw_we = 1'b0; tmr_ovf[0] = 1'b0;
        rd_chk("R6 hw set survives write", 2'd2, 8'h02);
        wr(2'd2, 8'h41);
        rd_chk("R6 software set", 2'd2, 8'h41);
        wr(2'd2, 8'h00);
        rd_chk("R6 software clear", 2'd2, 8'h00);

        // R11 / R12: nesting
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h20);
        wr(2'd2, 8'h02);
        vec_chk("R11 low winner", 1'b1, 3'd1);
        ack();
        vec_chk("R11 low in service", 1'b0, 3'd0);
        wr(2'd2, 8'h48);
        vec_chk("R11 high preempts", 1'b1, 3'd5);
        ack();
        vec_chk("R11 high not preempted", 1'b0, 3'd0);
        wr(2'd1, 8'h21);
        wr(2'd2, 8'h49);
        vec_chk("R11 high blocks high", 1'b0, 3'd0);
        ret();
        vec_chk("R12 hi released R9 order", 1'b1, 3'd0);
        ack();
        ret();
        vec_chk("R12 timer2 still pending", 1'b1, 3'd5);
        ack();
        ret();
        wr(2'd2, 8'h08);
        vec_chk("R11 low blocked by low", 1'b0, 3'd0);
        ret();
        vec_chk("R12 low released", 1'b1, 3'd3);
        wr(2'd2, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule